// File: doc/BRIEF.md
# Floating-Point Micro-Op Dispatch Buffer

This block sits between register rename and the floating-point execution pipes. Each cycle rename offers a group of up to four micro-ops. Every micro-op that writes a result gets a destination physical register from a free pool. The micro-ops then enter a selection window. An oldest-first overflow queue sits behind that window. The window has a fixed set of slots and is the only place where issue looks for work. It picks micro-ops whose source register already holds a result, without regard to program order, and sends up to two of them to the pipes each cycle. The queue holds micro-ops that do not yet fit in the window. It feeds them forward in order as slots open.

A group is taken in full or not at all. A group can be refused for two separate reasons: there is no room left in the window and queue together, or there are too few free destination registers. Each reason has its own flag and its own cycle counter, and both can be active in the same cycle. Registers go back to the pool through a release input that carries up to four tags per cycle. A completed result marks its register as valid through a write-back input, and that makes waiting consumers eligible for issue.

With default parameters the window has 36 slots, the queue has 64 entries (100 micro-ops in total) and the pool has 160 registers.

Top module: `fp_uop_buffer`

## Requirements
- R1: After synchronous reset: window and queue counts are 0, the free count is 160, every register is marked valid, `iss_valid` is 0, both stall counters are 0, and neither stall flag is high while `disp_cnt` is 0.
- R2: The lanes 0 to `disp_cnt`-1 of a group are taken together or not at all. If the queue is empty, the group fits when `disp_cnt` is at most the free window slots plus the queue depth. Otherwise it fits only when `disp_cnt` is at most the free queue entries. A group that does not fit raises `stall_sched` in that cycle, and the window and queue counts stay unchanged.
- R3: When the queue is empty, an accepted group fills free window slots first. Any lanes left over go to the queue in the same cycle.
- R4: When the queue holds entries, a new group goes to the queue tail. The queue moves its oldest entries into free window slots, at most four per cycle.
- R5: `stall_reg` is high when the number of lanes with `disp_has_dst` set exceeds `free_count`. A group with no destination lanes is not held back by an empty pool.
- R6: Lanes with `disp_has_dst` set receive the lowest-numbered free registers, in lane order, on `disp_dst` in the same cycle. `free_count` drops by that number after the accepting edge.
- R7: Every `rel_valid` lane returns its tag to the pool. `free_count` rises by the number of released tags after the edge.
- R8: Up to two eligible window entries issue per cycle, taken from the lowest slot index upward. Port 0 carries the lower slot. `iss_valid`, `iss_uid` and `iss_dst` appear one cycle after the edge that selects the entries.
- R9: A micro-op with `disp_has_src` set stays in the window while its source register is marked not valid. Allocating a register marks it not valid. A `wb_valid` tag marks it valid from that edge on, so consumers issue one cycle after that.
- R10: `stall_sched_cycles` and `stall_reg_cycles` each increase by one for every cycle in which their flag is high.
- R11: When both causes apply in one cycle, both flags rise together, both counters advance, and no register is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_cnt | input | 3 | Number of valid lanes in the offered group, lanes 0 upward |
| disp_has_dst | input | 4 | Per lane: micro-op writes a register |
| disp_has_src | input | 4 | Per lane: micro-op waits on a source register |
| disp_src | input | 32 | Per lane 8-bit source register tag |
| disp_uid | input | 32 | Per lane 8-bit micro-op identifier |
| disp_dst | output | 32 | Per lane 8-bit granted destination tag |
| stall_sched | output | 1 | Group refused for lack of window/queue room |
| stall_reg | output | 1 | Group refused for lack of free registers |
| rel_valid | input | 4 | Per lane register release strobe |
| rel_tag | input | 32 | Per lane 8-bit tag to release |
| wb_valid | input | 2 | Per port result write-back strobe |
| wb_tag | input | 16 | Per port 8-bit written-back tag |
| iss_valid | output | 2 | Per pipe issue strobe |
| iss_uid | output | 16 | Per pipe identifier of the issued micro-op |
| iss_dst | output | 16 | Per pipe destination tag of the issued micro-op |
| sched_count | output | 6 | Occupied window slots |
| nsq_count | output | 7 | Occupied queue entries |
| free_count | output | 8 | Free registers in the pool |
| stall_sched_cycles | output | 32 | Cycles with `stall_sched` high |
| stall_reg_cycles | output | 32 | Cycles with `stall_reg` high |

## Verification
The two refusal causes can arise in the same cycle, and they must be reported independently. The bench first holds the window with micro-ops that wait on a register nobody writes back. It then fills the queue until only two entries remain and drains the pool to zero registers. A four-lane group that writes four registers is then offered. Both flags must be high in that cycle, each counter must advance by exactly one, and the free count must not move. Before this, the bench offers groups that trip only one cause, and a group with no destination lanes that must still be taken while the pool is empty.

// File: rtl/fpq_pkg.sv
package fpq_pkg;

  localparam int unsigned TAG_W = 8;
  localparam int unsigned UID_W = 8;

  typedef struct packed {
    logic [UID_W-1:0] uid;
    logic             has_src;
    logic [TAG_W-1:0] src;
    logic             has_dst;
    logic [TAG_W-1:0] dst;
  } uop_t;

endpackage

// File: rtl/fpq_reg_pool.sv
module fpq_reg_pool
  import fpq_pkg::*;
#(
  parameter int unsigned PREGS = 160,
  parameter int unsigned LANES = 4,
  parameter int unsigned WB_W  = 2,
  localparam int unsigned CNT_W = $clog2(PREGS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] alloc_req,
  input  logic             alloc_en,
  output logic [TAG_W-1:0] alloc_tag [LANES],
  input  logic [LANES-1:0] rel_valid,
  input  logic [TAG_W-1:0] rel_tag   [LANES],
  input  logic [WB_W-1:0]  wb_valid,
  input  logic [TAG_W-1:0] wb_tag    [WB_W],
  output logic [PREGS-1:0] ready_vec,
  output logic [CNT_W-1:0] free_cnt
);

  logic [PREGS-1:0] free_q, free_d, ready_q, ready_d;
  logic [CNT_W-1:0] free_cnt_q;
  logic [TAG_W-1:0] cand [LANES];

  // lowest free registers, in ascending order
  always_comb begin
    int k;
    k = 0;
    for (int l = 0; l < LANES; l++) cand[l] = '0;
    for (int r = 0; r < PREGS; r++) begin
      if (free_q[r] && k < LANES) begin
        cand[k] = TAG_W'(r);
        k++;
      end
    end
  end

  // lane l takes the n-th candidate, n = destination lanes below l
  always_comb begin
    int n;
    n = 0;
    for (int l = 0; l < LANES; l++) begin
      alloc_tag[l] = cand[n];
      if (alloc_req[l]) n++;
    end
  end

  always_comb begin
    free_d  = free_q;
    ready_d = ready_q;
    for (int l = 0; l < LANES; l++)
      if (rel_valid[l]) free_d[rel_tag[l]] = 1'b1;
    for (int w = 0; w < int'(WB_W); w++)
      if (wb_valid[w]) ready_d[wb_tag[w]] = 1'b1;
    if (alloc_en) begin
      for (int l = 0; l < LANES; l++) begin
        if (alloc_req[l]) begin
          free_d[alloc_tag[l]]  = 1'b0;
          ready_d[alloc_tag[l]] = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      free_q     <= '1;
      ready_q    <= '1;
      free_cnt_q <= CNT_W'(PREGS);
    end else begin
      free_q     <= free_d;
      ready_q    <= ready_d;
      free_cnt_q <= free_cnt_q + CNT_W'($countones(rel_valid))
                    - (alloc_en ? CNT_W'($countones(alloc_req)) : CNT_W'(0));
    end
  end

  assign ready_vec = ready_q;
  assign free_cnt  = free_cnt_q;

  // R6 R7: counter and bit vector are kept in step
  p_free_cnt_bits_r6: assert property (@(posedge clk) disable iff (rst)
    $countones(free_q) == int'(free_cnt_q));

  for (genvar g = 0; g < LANES; g++) begin : g_rel_chk
    // R7: only a held register may be released
    p_release_busy_r7: assert property (@(posedge clk) disable iff (rst)
      rel_valid[g] |-> !free_q[rel_tag[g]]);
  end

endmodule

// File: rtl/fpq_overflow_q.sv
module fpq_overflow_q
  import fpq_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned LANES = 4,
  localparam int unsigned IW  = $clog2(DEPTH),
  localparam int unsigned CW  = $clog2(DEPTH + 1),
  localparam int unsigned LW  = $clog2(LANES + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [LW-1:0] push_n,
  input  uop_t          push_data [LANES],
  input  logic [LW-1:0] pop_n,
  output uop_t          pop_data  [LANES],
  output logic [CW-1:0] count
);

  uop_t          mem [DEPTH];
  logic [IW-1:0] head_q, tail_q;
  logic [CW-1:0] count_q;

  function automatic logic [IW-1:0] wrap(input int base, input int off);
    int s;
    s = base + off;
    if (s >= int'(DEPTH)) s = s - int'(DEPTH);
    return IW'(s);
  endfunction

  always_comb
    for (int i = 0; i < LANES; i++) pop_data[i] = mem[wrap(int'(head_q), i)];

  always_ff @(posedge clk)
    for (int i = 0; i < LANES; i++)
      if (i < int'(push_n)) mem[wrap(int'(tail_q), i)] <= push_data[i];

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      head_q  <= wrap(int'(head_q), int'(pop_n));
      tail_q  <= wrap(int'(tail_q), int'(push_n));
      count_q <= count_q + CW'(push_n) - CW'(pop_n);
    end
  end

  assign count = count_q;

  // R4: the queue never drains more than it holds
  p_no_underflow_r4: assert property (@(posedge clk) disable iff (rst)
    int'(pop_n) <= int'(count_q));
  // R2: acceptance never overfills the queue
  p_no_overflow_r2: assert property (@(posedge clk) disable iff (rst)
    int'(count_q) + int'(push_n) - int'(pop_n) <= int'(DEPTH));

endmodule

// File: rtl/fpq_sched_win.sv
module fpq_sched_win
  import fpq_pkg::*;
#(
  parameter int unsigned SLOTS   = 36,
  parameter int unsigned LANES   = 4,
  parameter int unsigned ISSUE_W = 2,
  parameter int unsigned PREGS   = 160,
  localparam int unsigned CW = $clog2(SLOTS + 1),
  localparam int unsigned LW = $clog2(LANES + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [LW-1:0]      ins_n,
  input  uop_t               ins_data [LANES],
  input  logic [PREGS-1:0]   ready_vec,
  output logic [ISSUE_W-1:0] iss_valid,
  output uop_t               iss_uop  [ISSUE_W],
  output logic [CW-1:0]      count
);

  logic [SLOTS-1:0]   valid_q, elig;
  uop_t               ent_q [SLOTS];
  int                 fslot [LANES];
  int                 sel   [ISSUE_W];
  logic [ISSUE_W-1:0] sel_ok, iss_valid_q;
  uop_t               iss_q [ISSUE_W];
  logic [CW-1:0]      count_q;

  // free slot search, lowest index first
  always_comb begin
    int k;
    k = 0;
    for (int l = 0; l < LANES; l++) fslot[l] = 0;
    for (int s = 0; s < SLOTS; s++) begin
      if (!valid_q[s] && k < LANES) begin
        fslot[k] = s;
        k++;
      end
    end
  end

  // eligibility and pick, lowest slot to port 0
  always_comb begin
    int j;
    j = 0;
    for (int p = 0; p < int'(ISSUE_W); p++) begin
      sel[p]    = 0;
      sel_ok[p] = 1'b0;
    end
    for (int s = 0; s < SLOTS; s++) begin
      elig[s] = valid_q[s] && (!ent_q[s].has_src || ready_vec[ent_q[s].src]);
      if (elig[s] && j < int'(ISSUE_W)) begin
        sel[j]    = s;
        sel_ok[j] = 1'b1;
        j++;
      end
    end
  end

  always_ff @(posedge clk)
    for (int l = 0; l < LANES; l++)
      if (l < int'(ins_n)) ent_q[fslot[l]] <= ins_data[l];

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q     <= '0;
      iss_valid_q <= '0;
      count_q     <= '0;
    end else begin
      for (int p = 0; p < int'(ISSUE_W); p++)
        if (sel_ok[p]) valid_q[sel[p]] <= 1'b0;
      for (int l = 0; l < LANES; l++)
        if (l < int'(ins_n)) valid_q[fslot[l]] <= 1'b1;
      iss_valid_q <= sel_ok;
      count_q     <= count_q + CW'(ins_n) - CW'($countones(sel_ok));
    end
  end

  always_ff @(posedge clk)
    for (int p = 0; p < int'(ISSUE_W); p++) iss_q[p] <= ent_q[sel[p]];

  assign iss_valid = iss_valid_q;
  assign iss_uop   = iss_q;
  assign count     = count_q;

  // R3 R4: inserts never exceed the open slots
  p_insert_room_r3: assert property (@(posedge clk) disable iff (rst)
    int'(ins_n) <= int'(SLOTS) - int'(count_q));
  // R8: occupancy counter tracks the slot flags
  p_count_slots_r8: assert property (@(posedge clk) disable iff (rst)
    $countones(valid_q) == int'(count_q));
  // R8: a higher port is used only when port 0 is used
  p_port_fill_r8: assert property (@(posedge clk) disable iff (rst)
    iss_valid[ISSUE_W-1] |-> iss_valid[0]);

endmodule

// File: rtl/fp_uop_buffer.sv
module fp_uop_buffer
  import fpq_pkg::*;
#(
  parameter int unsigned LANES       = 4,
  parameter int unsigned SLOTS       = 36,
  parameter int unsigned NSQ_DEPTH   = 64,
  parameter int unsigned PREGS       = 160,
  parameter int unsigned ISSUE_W     = 2,
  parameter int unsigned STALL_CNT_W = 32,
  localparam int unsigned LW  = $clog2(LANES + 1),
  localparam int unsigned SCW = $clog2(SLOTS + 1),
  localparam int unsigned NQW = $clog2(NSQ_DEPTH + 1),
  localparam int unsigned FCW = $clog2(PREGS + 1)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [LW-1:0]            disp_cnt,
  input  logic [LANES-1:0]         disp_has_dst,
  input  logic [LANES-1:0]         disp_has_src,
  input  logic [LANES*TAG_W-1:0]   disp_src,
  input  logic [LANES*UID_W-1:0]   disp_uid,
  output logic [LANES*TAG_W-1:0]   disp_dst,
  output logic                     stall_sched,
  output logic                     stall_reg,
  input  logic [LANES-1:0]         rel_valid,
  input  logic [LANES*TAG_W-1:0]   rel_tag,
  input  logic [ISSUE_W-1:0]       wb_valid,
  input  logic [ISSUE_W*TAG_W-1:0] wb_tag,
  output logic [ISSUE_W-1:0]       iss_valid,
  output logic [ISSUE_W*UID_W-1:0] iss_uid,
  output logic [ISSUE_W*TAG_W-1:0] iss_dst,
  output logic [SCW-1:0]           sched_count,
  output logic [NQW-1:0]           nsq_count,
  output logic [FCW-1:0]           free_count,
  output logic [STALL_CNT_W-1:0]   stall_sched_cycles,
  output logic [STALL_CNT_W-1:0]   stall_reg_cycles
);

  logic [LANES-1:0] lane_on, dst_req;
  logic [TAG_W-1:0] alloc_tag [LANES];
  logic [TAG_W-1:0] rel_tag_a [LANES];
  logic [TAG_W-1:0] wb_tag_a  [ISSUE_W];
  logic [PREGS-1:0] ready_vec;
  uop_t             lane_uop  [LANES];
  uop_t             push_data [LANES];
  uop_t             pop_data  [LANES];
  uop_t             ins_data  [LANES];
  uop_t             iss_uop   [ISSUE_W];
  logic [LW-1:0]    push_n, pop_n, ins_n;
  logic             accept, room_ok;
  int               sched_free, nsq_free, direct_n, drain_n;
  logic [STALL_CNT_W-1:0] ss_cnt_q, sr_cnt_q;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_on[l]   = (l < int'(disp_cnt));
    assign dst_req[l]   = lane_on[l] && disp_has_dst[l];
    assign rel_tag_a[l] = rel_tag[l*TAG_W +: TAG_W];
    assign disp_dst[l*TAG_W +: TAG_W] = alloc_tag[l];
    assign lane_uop[l] = '{uid: disp_uid[l*UID_W +: UID_W], has_src: disp_has_src[l],
                           src: disp_src[l*TAG_W +: TAG_W], has_dst: disp_has_dst[l],
                           dst: alloc_tag[l]};
  end

  for (genvar p = 0; p < ISSUE_W; p++) begin : g_port
    assign wb_tag_a[p] = wb_tag[p*TAG_W +: TAG_W];
    assign iss_uid[p*UID_W +: UID_W] = iss_uop[p].uid;
    assign iss_dst[p*TAG_W +: TAG_W] = iss_uop[p].dst;
  end

  // room and acceptance for the offered group
  always_comb begin
    sched_free  = int'(SLOTS) - int'(sched_count);
    nsq_free    = int'(NSQ_DEPTH) - int'(nsq_count);
    room_ok     = (nsq_count == '0) ? (int'(disp_cnt) <= sched_free + int'(NSQ_DEPTH))
                                    : (int'(disp_cnt) <= nsq_free);
    stall_sched = (disp_cnt != '0) && !room_ok;
    stall_reg   = (disp_cnt != '0) && ($countones(dst_req) > int'(free_count));
    accept      = (disp_cnt != '0) && !stall_sched && !stall_reg;
  end

  // routing: direct into the window only while the queue is empty
  always_comb begin
    direct_n = 0;
    drain_n  = 0;
    if (nsq_count == '0) begin
      if (accept) direct_n = (int'(disp_cnt) < sched_free) ? int'(disp_cnt) : sched_free;
    end else begin
      drain_n = (int'(nsq_count) < sched_free) ? int'(nsq_count) : sched_free;
      if (drain_n > int'(LANES)) drain_n = int'(LANES);
    end
    push_n = accept ? LW'(int'(disp_cnt) - direct_n) : '0;
    pop_n  = LW'(drain_n);
    ins_n  = LW'(direct_n + drain_n);
    for (int i = 0; i < LANES; i++) begin
      push_data[i] = (direct_n + i < int'(LANES)) ? lane_uop[direct_n + i] : lane_uop[0];
      ins_data[i]  = (nsq_count != '0) ? pop_data[i] : lane_uop[i];
    end
  end

  fpq_reg_pool #(.PREGS(PREGS), .LANES(LANES), .WB_W(ISSUE_W)) u_pool (
    .clk(clk), .rst(rst), .alloc_req(dst_req), .alloc_en(accept),
    .alloc_tag(alloc_tag), .rel_valid(rel_valid), .rel_tag(rel_tag_a),
    .wb_valid(wb_valid), .wb_tag(wb_tag_a), .ready_vec(ready_vec),
    .free_cnt(free_count)
  );

  fpq_overflow_q #(.DEPTH(NSQ_DEPTH), .LANES(LANES)) u_nsq (
    .clk(clk), .rst(rst), .push_n(push_n), .push_data(push_data),
    .pop_n(pop_n), .pop_data(pop_data), .count(nsq_count)
  );

  fpq_sched_win #(.SLOTS(SLOTS), .LANES(LANES), .ISSUE_W(ISSUE_W), .PREGS(PREGS)) u_win (
    .clk(clk), .rst(rst), .ins_n(ins_n), .ins_data(ins_data),
    .ready_vec(ready_vec), .iss_valid(iss_valid), .iss_uop(iss_uop),
    .count(sched_count)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ss_cnt_q <= '0;
      sr_cnt_q <= '0;
    end else begin
      if (stall_sched) ss_cnt_q <= ss_cnt_q + 1'b1;
      if (stall_reg)   sr_cnt_q <= sr_cnt_q + 1'b1;
    end
  end

  assign stall_sched_cycles = ss_cnt_q;
  assign stall_reg_cycles   = sr_cnt_q;

  // R2: a room refusal needs the queue within one group of full
  p_room_stall_r2: assert property (@(posedge clk) disable iff (rst)
    stall_sched |-> int'(nsq_count) > int'(NSQ_DEPTH) - int'(LANES));
  // R5: a register refusal needs fewer free registers than lanes
  p_reg_stall_r5: assert property (@(posedge clk) disable iff (rst)
    stall_reg |-> int'(free_count) < int'(LANES));
  // R10: each flag advances its counter by one
  p_sched_cnt_r10: assert property (@(posedge clk) disable iff (rst)
    stall_sched |=> stall_sched_cycles == $past(stall_sched_cycles) + 1'b1);
  p_reg_cnt_r10: assert property (@(posedge clk) disable iff (rst)
    stall_reg |=> stall_reg_cycles == $past(stall_reg_cycles) + 1'b1);
  // R11: a refused group takes no register
  p_no_take_r11: assert property (@(posedge clk) disable iff (rst)
    (stall_sched || stall_reg) |=> free_count >= $past(free_count));
  // R3: the queue only grows from a direct fill when the window was near full
  p_direct_first_r3: assert property (@(posedge clk) disable iff (rst)
    (accept && nsq_count == '0 && int'(disp_cnt) <= sched_free) |=> nsq_count == '0);

endmodule

// File: tb/fp_uop_buffer_tb_top.sv
module fp_uop_buffer_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  disp_cnt = '0;
  logic [3:0]  disp_has_dst = '0, disp_has_src = '0;
  logic [31:0] disp_src = '0, disp_uid = '0;
  logic [31:0] disp_dst;
  logic        stall_sched, stall_reg;
  logic [3:0]  rel_valid = '0;
  logic [31:0] rel_tag = '0;
  logic [1:0]  wb_valid = '0;
  logic [15:0] wb_tag = '0;
  logic [1:0]  iss_valid;
  logic [15:0] iss_uid, iss_dst;
  logic [5:0]  sched_count;
  logic [6:0]  nsq_count;
  logic [7:0]  free_count;
  logic [31:0] stall_sched_cycles, stall_reg_cycles;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  fp_uop_buffer dut_i (
    .clk(clk), .rst(rst), .disp_cnt(disp_cnt), .disp_has_dst(disp_has_dst),
    .disp_has_src(disp_has_src), .disp_src(disp_src), .disp_uid(disp_uid),
    .disp_dst(disp_dst), .stall_sched(stall_sched), .stall_reg(stall_reg),
    .rel_valid(rel_valid), .rel_tag(rel_tag), .wb_valid(wb_valid), .wb_tag(wb_tag),
    .iss_valid(iss_valid), .iss_uid(iss_uid), .iss_dst(iss_dst),
    .sched_count(sched_count), .nsq_count(nsq_count), .free_count(free_count),
    .stall_sched_cycles(stall_sched_cycles), .stall_reg_cycles(stall_reg_cycles)
  );

  // fields: cnt[27:25] dst mask[24:21] exp window[20:15] exp queue[14:8] exp free[7:0]
  localparam logic [27:0] TBL [12] = '{
    {3'd4, 4'b1111, 6'd4,  7'd0, 8'd155},
    {3'd3, 4'b0101, 6'd7,  7'd0, 8'd153},
    {3'd4, 4'b0000, 6'd11, 7'd0, 8'd153},
    {3'd4, 4'b1111, 6'd15, 7'd0, 8'd149},
    {3'd4, 4'b1111, 6'd19, 7'd0, 8'd145},
    {3'd4, 4'b1111, 6'd23, 7'd0, 8'd141},
    {3'd4, 4'b1111, 6'd27, 7'd0, 8'd137},
    {3'd4, 4'b1111, 6'd31, 7'd0, 8'd133},
    {3'd4, 4'b0011, 6'd35, 7'd0, 8'd131},
    {3'd4, 4'b1111, 6'd36, 7'd3, 8'd127},
    {3'd2, 4'b0001, 6'd36, 7'd5, 8'd126},
    {3'd0, 4'b0000, 6'd36, 7'd5, 8'd126}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic offer(input int cnt, input logic [3:0] mask, input bit src_on,
                       input int src, input int base);
    disp_cnt     = 3'(cnt);
    disp_has_dst = mask;
    for (int l = 0; l < 4; l++) begin
      disp_has_src[l]     = src_on;
      disp_src[l*8 +: 8]  = 8'(src);
      disp_uid[l*8 +: 8]  = 8'(base + l);
    end
    #1;
  endtask

  task automatic idle();
    disp_cnt     = '0;
    disp_has_dst = '0;
    disp_has_src = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int issued;
    repeat (3) tick();
    rst = 1'b0;
    #1;
    // R1 reset state
    chk("R1 window", int'(sched_count), 0);
    chk("R1 queue", int'(nsq_count), 0);
    chk("R1 free", int'(free_count), 160);
    chk("R1 issue", int'(iss_valid), 0);
    chk("R1 flags", int'({stall_sched, stall_reg}), 0);
    chk("R1 counters", int'(stall_sched_cycles + stall_reg_cycles), 0);

    // prelude: one ready uop writing reg 0, which stays not valid
    offer(1, 4'b0001, 1'b0, 0, 1);
    chk("R6 first tag", int'(disp_dst[7:0]), 0);
    tick(); idle();
    chk("R8 not yet issued", int'(iss_valid), 0);
    tick();
    chk("R8 issue strobe", int'(iss_valid), 1);
    chk("R8 issue uid", int'(iss_uid[7:0]), 1);
    chk("R8 issue dst", int'(iss_dst[7:0]), 0);
    repeat (3) tick();

    // table phase: every uop waits on reg 0
    for (int s = 0; s < 12; s++) begin
      offer(int'(TBL[s][27:25]), TBL[s][24:21], 1'b1, 0, 16 + 4*s);
      chk("R2 no refusal", int'({stall_sched, stall_reg}), 0);
      tick(); idle();
      chk("R3 R4 window", int'(sched_count), int'(TBL[s][20:15]));
      chk("R3 R4 queue", int'(nsq_count), int'(TBL[s][14:8]));
      chk("R6 free", int'(free_count), int'(TBL[s][7:0]));
      chk("R9 waiting", int'(iss_valid), 0);
    end

    // R2 fill queue to 61, then refuse a group of four
    for (int g = 0; g < 14; g++) begin
      offer(4, 4'b0000, 1'b1, 0, 100);
      tick(); idle();
    end
    chk("R4 queue 61", int'(nsq_count), 61);
    offer(4, 4'b0000, 1'b1, 0, 100);
    chk("R2 refusal flag", int'(stall_sched), 1);
    chk("R5 no reg flag", int'(stall_reg), 0);
    tick(); idle();
    chk("R2 queue unchanged", int'(nsq_count), 61);
    chk("R2 window unchanged", int'(sched_count), 36);
    chk("R10 room counter", int'(stall_sched_cycles), 1);
    offer(3, 4'b0000, 1'b1, 0, 100);
    chk("R2 exact fit", int'(stall_sched), 0);
    tick(); idle();
    chk("R2 queue full", int'(nsq_count), 64);
    offer(1, 4'b0000, 1'b1, 0, 100);
    chk("R2 full refusal", int'(stall_sched), 1);
    tick(); idle();
    chk("R10 room counter 2", int'(stall_sched_cycles), 2);

    // R9 write back reg 0: everything becomes eligible
    wb_valid = 2'b01; wb_tag = '0;
    tick();
    wb_valid = '0;
    chk("R9 no issue at wb edge", int'(iss_valid), 0);
    tick();
    chk("R9 issue after wb", int'(iss_valid), 3);
    chk("R8 port0 lowest slot", int'(iss_uid[7:0]), 16);
    chk("R8 port1 next slot", int'(iss_uid[15:8]), 17);
    issued = 2;
    for (int c = 0; c < 70; c++) begin
      tick();
      issued += $countones(iss_valid);
    end
    chk("R4 all drained", issued, 100);
    chk("R4 window empty", int'(sched_count), 0);
    chk("R4 queue empty", int'(nsq_count), 0);

    // R7 release tags 0..3
    rel_valid = 4'b1111;
    for (int l = 0; l < 4; l++) rel_tag[l*8 +: 8] = 8'(l);
    tick();
    rel_valid = '0;
    chk("R7 free after release", int'(free_count), 130);

    // R6 lowest free first: 0..3 then 34..37; these uops issue and leave
    for (int g = 0; g < 8; g++) begin
      offer(4, 4'b1111, 1'b0, 0, 200);
      if (g == 0) begin
        chk("R6 lane0", int'(disp_dst[7:0]), 0);
        chk("R6 lane3", int'(disp_dst[31:24]), 3);
      end
      if (g == 1) begin
        chk("R6 skip held lane0", int'(disp_dst[7:0]), 34);
        chk("R6 skip held lane3", int'(disp_dst[31:24]), 37);
      end
      tick(); idle();
    end
    repeat (30) tick();
    chk("R6 free 98", int'(free_count), 98);

    // hold 96 uops on reg 5 (never written back)
    for (int g = 0; g < 24; g++) begin
      offer(4, 4'b1111, 1'b1, 5, 50);
      tick(); idle();
    end
    chk("R3 window full", int'(sched_count), 36);
    chk("R4 queue 60", int'(nsq_count), 60);
    chk("R6 free 2", int'(free_count), 2);

    offer(4, 4'b1111, 1'b1, 5, 50);
    chk("R5 reg refusal", int'(stall_reg), 1);
    chk("R2 room ok", int'(stall_sched), 0);
    tick(); idle();
    chk("R5 free unchanged", int'(free_count), 2);
    chk("R5 queue unchanged", int'(nsq_count), 60);
    chk("R10 reg counter", int'(stall_reg_cycles), 1);

    offer(2, 4'b0011, 1'b1, 5, 50);
    chk("R5 fits", int'({stall_sched, stall_reg}), 0);
    tick(); idle();
    chk("R5 pool empty", int'(free_count), 0);
    chk("R4 queue 62", int'(nsq_count), 62);

    offer(4, 4'b1111, 1'b1, 5, 50);
    chk("R11 both flags", int'({stall_sched, stall_reg}), 3);
    tick(); idle();
    chk("R11 room counter", int'(stall_sched_cycles), 3);
    chk("R11 reg counter", int'(stall_reg_cycles), 2);
    chk("R11 free held", int'(free_count), 0);

    offer(1, 4'b0000, 1'b1, 5, 50);
    chk("R5 no dst not held", int'({stall_sched, stall_reg}), 0);
    tick(); idle();
    chk("R5 queue 63", int'(nsq_count), 63);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule